// File: doc/BRIEF.md
# Ethernet Receive Frame Status Generator

This block watches one received Ethernet frame as it arrives on a 4-bit media-independent nibble stream. Each nibble is qualified by a data-valid input. A receive-error input and a collision input are sampled alongside the data. Preamble and start-of-frame have already been removed upstream, so the first valid nibble is the low half of the first destination-address byte.

While the frame arrives, the block counts nibbles and bytes and runs a CRC-32 over every complete byte. It also captures the first address byte and the Length/Type bytes. It records any receive error, and any collision seen after the collision window.

When data-valid drops, the block raises a one-cycle strobe carrying a 12-bit status word and a pass/drop decision. A configuration input decides whether frames with errors are still passed on. A downstream frame store uses the decision to keep or discard the frame and saves the status word with it.

Top module: `rx_frame_status`

## Requirements
- R1: `stat_valid` is high for exactly one cycle. It rises on the clock edge after the first edge at which `rx_dv` is sampled low following a cycle in which it was high.
- R2: Bit 11 (runt) is set when the frame holds fewer than 64 complete bytes.
- R3: Bit 10 (multicast) equals bit 0 of the first byte. A byte is formed from two nibbles, low nibble first.
- R4: Bit 7 (too long) is set when the frame holds more than 1518 complete bytes. Reception is not truncated: every byte still goes into the CRC.
- R5: Bit 6 (late collision) is set when `rx_col` is high during data-valid while 64 or more complete bytes have already been received.
- R6: Bit 5 (frame type) is set when the frame holds at least 14 bytes and the 16-bit value of bytes 12 and 13 (byte 12 most significant) is greater than 1500.
- R7: Bit 4 (watchdog) is set when the frame holds more than 2048 complete bytes.
- R8: Bit 3 (line error) is set when `rx_er` is high in any data-valid cycle of the frame.
- R9: Bit 2 (dribble) is set when the frame ends on an odd nibble, but not when bit 6 is set. The trailing half byte is left out of the CRC, so a dribble frame with a correct CRC passes.
- R10: Bit 1 (CRC error) is set when the CRC-32 over all complete bytes does not leave the residue 0xDEBB20E3, or when bit 3 is set. It is cleared whenever bit 11, bit 6 or bit 4 is set.
- R11: Status bits 9, 8 and 0 are always 0.
- R12: `stat_pass` is 1 unless one of bits 11, 7, 6, 4, 3 or 1 is set. When `cfg_pass_bad` is 1 at the clock edge that captures the status, `stat_pass` is always 1.
- R13: After reset, `stat_valid`, `stat_word` and `stat_pass` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_dv | input | 1 | Nibble valid; high for the whole frame |
| rxd | input | 4 | Receive nibble, low nibble of each byte first |
| rx_er | input | 1 | Receive error from the line interface |
| rx_col | input | 1 | Collision indication |
| cfg_pass_bad | input | 1 | Pass frames that have error flags set |
| stat_valid | output | 1 | One-cycle strobe at end of frame |
| stat_word | output | 12 | Frame status flags |
| stat_pass | output | 1 | 1 = keep frame, 0 = drop |

## Verification
On every cycle, the assertions check that the strobe is single-cycle and follows a fall of data-valid. They also check these flag relationships: CRC error is masked by runt, late collision and watchdog; dribble is masked by late collision; watchdog implies too long; a bad frame is dropped unless passing is enabled. They also check that the nibble counter steps by one and that the multicast flag is captured from the first byte. The exact frame-length thresholds at 64, 1518 and 2048 bytes, the Length/Type comparison at 1500, and the handling of collisions on either side of the window can only be shown by the bench's scenarios. The same holds for the CRC residue over real frames, including a dribble nibble that must stay out of the CRC.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  localparam int BIT_RUNT  = 11;
  localparam int BIT_MCAST = 10;
  localparam int BIT_LONG  = 7;
  localparam int BIT_LATE  = 6;
  localparam int BIT_FTYPE = 5;
  localparam int BIT_WDOG  = 4;
  localparam int BIT_LNERR = 3;
  localparam int BIT_DRIB  = 2;
  localparam int BIT_CRC   = 1;

  localparam logic [31:0] CRC_SEED    = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_LR = 32'hEDB8_8320;
  localparam logic [31:0] CRC_GOOD    = 32'hDEBB_20E3;

  typedef struct packed {
    logic runt;
    logic mcast;
    logic too_long;
    logic late_col;
    logic frame_type;
    logic wdog;
    logic line_err;
    logic dribble;
    logic crc_err;
  } rx_flags_t;

  // LSB-first CRC-32 update, one nibble at a time
  function automatic logic [31:0] crc_nibble(input logic [31:0] c_in, input logic [3:0] n);
    logic [31:0] c;
    c = c_in;
    for (int i = 0; i < 4; i++) begin
      if (c[0] ^ n[i]) c = (c >> 1) ^ CRC_POLY_LR;
      else             c = c >> 1;
    end
    return c;
  endfunction

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    return crc_nibble(crc_nibble(c, b[3:0]), b[7:4]);
  endfunction

  function automatic logic [11:0] pack_status(input rx_flags_t f);
    logic [11:0] s;
    s = '0;
    s[BIT_RUNT]  = f.runt;
    s[BIT_MCAST] = f.mcast;
    s[BIT_LONG]  = f.too_long;
    s[BIT_LATE]  = f.late_col;
    s[BIT_FTYPE] = f.frame_type;
    s[BIT_WDOG]  = f.wdog;
    s[BIT_LNERR] = f.line_err;
    s[BIT_DRIB]  = f.dribble;
    s[BIT_CRC]   = f.crc_err;
    return s;
  endfunction

  function automatic logic frame_is_bad(input rx_flags_t f);
    return f.runt | f.too_long | f.late_col | f.wdog | f.line_err | f.crc_err;
  endfunction

endpackage

// File: rtl/rxs_nib_counter.sv
module rxs_nib_counter #(
  parameter int NIB_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nib_valid,
  input  logic [3:0]       nib,
  input  logic             clear,
  output logic [NIB_W-1:0] nib_cnt,
  output logic             byte_stb,
  output logic [7:0]       byte_val,
  output logic [NIB_W-2:0] byte_idx
);
  localparam logic [NIB_W-1:0] NIB_MAX = {NIB_W{1'b1}};

  logic [3:0] low_q;
  logic       saturated;
  logic       advance;

  assign saturated = (nib_cnt == NIB_MAX);
  assign advance   = nib_valid && !saturated;
  assign byte_stb  = advance && nib_cnt[0];
  assign byte_val  = {nib, low_q};
  assign byte_idx  = nib_cnt[NIB_W-1:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nib_cnt <= '0;
      low_q   <= '0;
    end else if (clear) begin
      nib_cnt <= '0;
    end else if (advance) begin
      nib_cnt <= nib_cnt + 1'b1;
      if (!nib_cnt[0]) low_q <= nib;
    end
  end

  // R2/R4 length basis: each accepted nibble moves the count by one
  assert_nibble_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_valid && !clear && nib_cnt != NIB_MAX) |=> nib_cnt == $past(nib_cnt) + 1'b1);

endmodule

// File: rtl/rxs_crc_check.sv
module rxs_crc_check (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       byte_stb,
  input  logic [7:0] byte_val,
  output logic       crc_match
);
  import rxs_pkg::*;

  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) crc_q <= CRC_SEED;
    else if (byte_stb)   crc_q <= crc_byte(crc_q, byte_val);
  end

  assign crc_match = (crc_q == CRC_GOOD);

  // R10: the register holds still between complete bytes
  assert_crc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_stb && !clear) |=> $stable(crc_q));

endmodule

// File: rtl/rxs_hdr_fields.sv
module rxs_hdr_fields #(
  parameter int IDX_W         = 12,
  parameter int TYPE_IDX      = 12,
  parameter int ETHERTYPE_MIN = 1500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             byte_stb,
  input  logic [7:0]       byte_val,
  input  logic [IDX_W-1:0] byte_idx,
  output logic             is_mcast,
  output logic             is_type_frame
);
  localparam logic [IDX_W-1:0] IDX_FIRST = '0;
  localparam logic [IDX_W-1:0] IDX_THI   = IDX_W'(TYPE_IDX);
  localparam logic [IDX_W-1:0] IDX_TLO   = IDX_W'(TYPE_IDX + 1);
  localparam logic [15:0]      TYPE_MIN  = 16'(ETHERTYPE_MIN);

  logic [7:0]  type_hi_q;
  logic [15:0] type_q;
  logic        type_seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      is_mcast    <= 1'b0;
      type_hi_q   <= '0;
      type_q      <= '0;
      type_seen_q <= 1'b0;
    end else if (byte_stb) begin
      if (byte_idx == IDX_FIRST) is_mcast  <= byte_val[0];
      if (byte_idx == IDX_THI)   type_hi_q <= byte_val;
      if (byte_idx == IDX_TLO) begin
        type_q      <= {type_hi_q, byte_val};
        type_seen_q <= 1'b1;
      end
    end
  end

  assign is_type_frame = type_seen_q && (type_q > TYPE_MIN);

  // R3: multicast follows the group bit of the first byte
  assert_mcast_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && !clear && byte_idx == IDX_FIRST) |=> is_mcast == $past(byte_val[0]));

endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status #(
  parameter int NIB_W         = 13,
  parameter int MIN_BYTES     = 64,
  parameter int MAX_BYTES     = 1518,
  parameter int WDOG_BYTES    = 2048,
  parameter int LATE_WINDOW   = 64,
  parameter int ETHERTYPE_MIN = 1500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_dv,
  input  logic [3:0]  rxd,
  input  logic        rx_er,
  input  logic        rx_col,
  input  logic        cfg_pass_bad,
  output logic        stat_valid,
  output logic [11:0] stat_word,
  output logic        stat_pass
);
  import rxs_pkg::*;

  localparam int BYTE_W = NIB_W - 1;
  localparam logic [BYTE_W-1:0] MIN_B  = BYTE_W'(MIN_BYTES);
  localparam logic [BYTE_W-1:0] MAX_B  = BYTE_W'(MAX_BYTES);
  localparam logic [BYTE_W-1:0] WDOG_B = BYTE_W'(WDOG_BYTES);
  localparam logic [BYTE_W-1:0] WIN_B  = BYTE_W'(LATE_WINDOW);

  logic              dv_q;
  logic              frame_end;
  logic [NIB_W-1:0]  nib_cnt;
  logic [BYTE_W-1:0] byte_cnt;
  logic              byte_stb;
  logic [7:0]        byte_val;
  logic [BYTE_W-1:0] byte_idx;
  logic              crc_match;
  logic              hdr_mcast;
  logic              hdr_type;
  logic              err_seen_q;
  logic              late_seen_q;
  logic              late_hit;
  rx_flags_t         flags;
  logic              bad_frame;

  assign frame_end = dv_q && !rx_dv;
  assign byte_cnt  = nib_cnt[NIB_W-1:1];
  assign late_hit  = rx_dv && rx_col && (byte_cnt >= WIN_B);

  rxs_nib_counter #(.NIB_W(NIB_W)) u_count (
    .clk(clk), .rst_n(rst_n), .nib_valid(rx_dv), .nib(rxd), .clear(frame_end),
    .nib_cnt(nib_cnt), .byte_stb(byte_stb), .byte_val(byte_val), .byte_idx(byte_idx)
  );

  rxs_crc_check u_crc (
    .clk(clk), .rst_n(rst_n), .clear(frame_end),
    .byte_stb(byte_stb), .byte_val(byte_val), .crc_match(crc_match)
  );

  rxs_hdr_fields #(.IDX_W(BYTE_W), .TYPE_IDX(12), .ETHERTYPE_MIN(ETHERTYPE_MIN)) u_hdr (
    .clk(clk), .rst_n(rst_n), .clear(frame_end), .byte_stb(byte_stb),
    .byte_val(byte_val), .byte_idx(byte_idx),
    .is_mcast(hdr_mcast), .is_type_frame(hdr_type)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dv_q        <= 1'b0;
      err_seen_q  <= 1'b0;
      late_seen_q <= 1'b0;
    end else begin
      dv_q <= rx_dv;
      if (frame_end) begin
        err_seen_q  <= 1'b0;
        late_seen_q <= 1'b0;
      end else begin
        if (rx_dv && rx_er) err_seen_q  <= 1'b1;
        if (late_hit)       late_seen_q <= 1'b1;
      end
    end
  end

  always_comb begin
    flags            = '0;
    flags.runt       = byte_cnt < MIN_B;
    flags.mcast      = hdr_mcast;
    flags.too_long   = byte_cnt > MAX_B;
    flags.late_col   = late_seen_q;
    flags.frame_type = hdr_type;
    flags.wdog       = byte_cnt > WDOG_B;
    flags.line_err   = err_seen_q;
    flags.dribble    = nib_cnt[0] && !late_seen_q;
    flags.crc_err    = (!crc_match || err_seen_q) &&
                       !(flags.runt || flags.late_col || flags.wdog);
    bad_frame        = frame_is_bad(flags);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_valid <= 1'b0;
      stat_word  <= '0;
      stat_pass  <= 1'b0;
    end else begin
      stat_valid <= frame_end;
      if (frame_end) begin
        stat_word <= pack_status(flags);
        stat_pass <= !bad_frame || cfg_pass_bad;
      end
    end
  end

  assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid);

  assert_strobe_after_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_valid) |-> ($past(dv_q) && !$past(rx_dv)));

  assert_crc_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && (stat_word[BIT_RUNT] || stat_word[BIT_LATE] || stat_word[BIT_WDOG]))
      |-> !stat_word[BIT_CRC]);

  assert_dribble_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_word[BIT_LATE]) |-> !stat_word[BIT_DRIB]);

  assert_wdog_long_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_word[BIT_WDOG]) |-> stat_word[BIT_LONG]);

  assert_drop_bad_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && !$past(cfg_pass_bad) &&
     (stat_word[BIT_RUNT] || stat_word[BIT_LONG] || stat_word[BIT_LATE] ||
      stat_word[BIT_WDOG] || stat_word[BIT_LNERR] || stat_word[BIT_CRC]))
      |-> !stat_pass);

endmodule

// File: tb/rx_frame_status_test.sv
module rx_frame_status_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_dv = 1'b0;
  logic [3:0]  rxd = '0;
  logic        rx_er = 1'b0;
  logic        rx_col = 1'b0;
  logic        cfg_pass_bad = 1'b0;
  logic        stat_valid;
  logic [11:0] stat_word;
  logic        stat_pass;

  int total = 0;
  int bad = 0;

  logic [7:0]  fbuf [0:2199];
  logic [12:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  rx_frame_status uut (
    .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rxd(rxd), .rx_er(rx_er),
    .rx_col(rx_col), .cfg_pass_bad(cfg_pass_bad),
    .stat_valid(stat_valid), .stat_word(stat_word), .stat_pass(stat_pass)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference CRC: whole-byte loop, transmitted complement appended LSB first
  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'h0, fbuf[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic send(input int len, input logic [7:0] dst0, input logic [15:0] typ,
                      input bit good_fcs, input bit extra, input int er_at,
                      input int col_at, input bit pass_cfg, input string tag);
    logic [31:0] fcs;
    logic [11:0] w;
    bit runt, lng, late, wd, lerr, crc, badf;
    for (int i = 0; i < len; i++) fbuf[i] = 8'(i * 7) ^ 8'h5A;
    fbuf[0] = dst0;
    if (len > 13) begin
      fbuf[12] = typ[15:8];
      fbuf[13] = typ[7:0];
    end
    fcs = ref_crc(len - 4);
    for (int k = 0; k < 4; k++) fbuf[len - 4 + k] = fcs[8*k +: 8];
    if (!good_fcs) fbuf[len - 1] = fbuf[len - 1] ^ 8'h01;
    // expected status from the requirements
    runt = len < 64;                          // R2
    lng  = len > 1518;                        // R4
    late = (col_at >= 64);                    // R5
    wd   = len > 2048;                        // R7
    lerr = (er_at >= 0);                      // R8
    crc  = (!good_fcs || lerr) && !runt && !late && !wd;  // R10
    w = '0;
    w[11] = runt;
    w[10] = fbuf[0][0];                       // R3
    w[7]  = lng;
    w[6]  = late;
    w[5]  = (len >= 14) && ({fbuf[12], fbuf[13]} > 16'd1500);  // R6
    w[4]  = wd;
    w[3]  = lerr;
    w[2]  = extra && !late;                   // R9
    w[1]  = crc;
    badf = runt | lng | late | wd | lerr | crc;
    exp_q.push_back({(!badf || pass_cfg), w});  // R12
    tag_q.push_back(tag);
    cfg_pass_bad = pass_cfg;
    for (int b = 0; b < len; b++) begin
      for (int h = 0; h < 2; h++) begin
        @(negedge clk);
        rx_dv  = 1'b1;
        rxd    = h ? fbuf[b][7:4] : fbuf[b][3:0];
        rx_er  = (b == er_at) && (h == 0);
        rx_col = (b == col_at) && (h == 0);
      end
    end
    if (extra) begin
      @(negedge clk);
      rxd = 4'hA; rx_er = 1'b0; rx_col = 1'b0;
    end
    @(negedge clk);
    rx_dv = 1'b0; rx_er = 1'b0; rx_col = 1'b0; rxd = '0;
    @(negedge clk);
    check(stat_valid === 1'b1, {"R1 strobe high ", tag}, int'(stat_valid), 1);
    @(negedge clk);
    check(stat_valid === 1'b0, {"R1 strobe one cycle ", tag}, int'(stat_valid), 0);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: compare each strobe against the scoreboard
  always @(negedge clk) begin
    if (rst_n && stat_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected status strobe", int'({stat_pass, stat_word}), 0);
      end else begin
        logic [12:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({stat_pass, stat_word} === e, t, int'({stat_pass, stat_word}), int'(e));
        check(stat_word[9:8] == 2'b00 && stat_word[0] == 1'b0,
              {"R11 reserved bits ", t}, int'(stat_word), int'(stat_word & 12'hCFE));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(stat_valid === 1'b0 && stat_word === 12'h0 && stat_pass === 1'b0,
          "R13 reset state", int'({stat_valid, stat_pass, stat_word}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    //    len  dst0   type      fcs ext er  col  cfg
    send(64,  8'h00, 16'h0800, 1, 0, -1, -1, 0, "R6 R12 good typed frame");
    send(60,  8'h00, 16'h0800, 1, 0, -1, -1, 0, "R2 R10 runt dropped");
    send(60,  8'h00, 16'h0800, 1, 0, -1, -1, 1, "R2 R12 runt passed");
    send(13,  8'h00, 16'h0000, 1, 0, -1, -1, 1, "R6 short frame no type");
    send(100, 8'h01, 16'h0040, 1, 0, -1, -1, 0, "R3 multicast length frame");
    send(100, 8'h02, 16'd1500, 1, 0, -1, -1, 0, "R6 type at 1500");
    send(100, 8'h02, 16'd1501, 1, 0, -1, -1, 0, "R6 type at 1501");
    send(80,  8'h00, 16'h0800, 0, 0, -1, -1, 0, "R10 bad fcs");
    send(80,  8'h00, 16'h0800, 1, 0, 20, -1, 0, "R8 R10 line error");
    send(80,  8'h00, 16'h0800, 1, 1, -1, -1, 0, "R9 dribble valid");
    send(80,  8'h00, 16'h0800, 0, 1, -1, 70, 0, "R5 R9 R10 late collision");
    send(80,  8'h00, 16'h0800, 1, 0, -1, 63, 0, "R5 collision inside window");
    send(1518, 8'h00, 16'h0800, 1, 0, -1, -1, 0, "R4 1518 bytes");
    send(1519, 8'h00, 16'h0800, 1, 0, -1, -1, 0, "R4 1519 bytes");
    send(2048, 8'h00, 16'h0800, 1, 0, -1, -1, 0, "R7 2048 bytes");
    send(2049, 8'h00, 16'h0800, 0, 0, -1, -1, 0, "R7 R10 2049 bytes");
    check(exp_q.size() == 0, "R1 every frame reported", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule